// File: doc/BRIEF.md
# Receive Word Aligner with Bitslip

This block sits on a receive parallel datapath, after the deserializer. It finds the word boundary inside a continuous stream of received bits and presents each output word on that boundary. Bit 0 of every input word is the earliest bit received. The aligner keeps the current input word and the word before it. It then selects a W-bit window that starts at a bit offset between 0 and W-1.

The offset can be moved in two ways. The first is a bitslip request, which steps the offset one bit at a time. The second is a pattern-align request, which searches all offsets for a programmable alignment pattern and locks onto the lowest offset that matches. The current offset is always reported as a slip count. In a deterministic-latency system, this count gives the bit delay that the aligner added.

A mode input selects the behaviour. Each output word carries a pattern-detect flag. A sync-status flag shows that the locked boundary has produced the pattern.

Top module: `rx_word_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `slip_cnt`, `sync_status`, `pattern_detect` and `data_out` are 0, and the offset is zero.
- R2: When `mode_sel` = 0 (bitslip mode), each rising edge of `bitslip` adds one to the offset. The offset equals `slip_cnt`. For a constant input X at offset s, `data_out[i]` = X[(i+s) mod W]. This means the earliest bit is dropped and the word starts one bit later.
- R3: `slip_cnt` never exceeds W-1. A slip taken at W-1 wraps the offset to 0.
- R4: A `bitslip` rising edge that comes within 2 cycles after an applied slip is ignored.
- R5: When `mode_sel` is 1, 2 or 3, `bitslip` has no effect on the offset or the output. Mode 3 (hold) also ignores `pattern_align`.
- R6: When `mode_sel` = 1 (manual mode) and W = 10, `pattern_align` acts on its level, after two resynchronizing flops. While it is high, the offset follows the pattern to wherever it appears.
- R7: In manual mode at any width other than 10, a rising edge of the resynchronized `pattern_align` arms one realignment. A pattern found later while the request stays high does not move the offset.
- R8: When `mode_sel` = 2 (deterministic-latency mode), `pattern_align` is edge triggered at every width, including W = 10.
- R9: A realignment sets the offset to the lowest offset s at which `data_out` equals `align_pattern`. After it, `slip_cnt` = s and `data_out` = `align_pattern`.
- R10: For each output word, `pattern_detect` is high exactly when `data_out` equals `align_pattern`.
- R11: `sync_status` is 0 in any cycle in which `slip_cnt` has just changed. It goes to 1 when an output word at the current offset equals the pattern, and it stays at 1 until the offset changes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0 bitslip, 1 manual, 2 deterministic latency, 3 hold |
| data_in | input | W | Raw deserialized word, bit 0 earliest |
| bitslip | input | 1 | Slip request, acts on its rising edge |
| pattern_align | input | 1 | Asynchronous realignment request |
| align_pattern | input | W | Alignment pattern to search for |
| data_out | output | W | Word on the selected boundary |
| pattern_detect | output | 1 | Output word equals the pattern |
| sync_status | output | 1 | Locked boundary has produced the pattern |
| slip_cnt | output | $clog2(W) | Current bit offset |

## Verification
A wrong offset register shows up two cycles later as `data_out`, which equals a rotation of a constant input by the wrong amount. It shows up one cycle later as a `slip_cnt` value that differs from the count of accepted slip edges. A broken holdoff or a broken edge-arming flop shows up as an extra step in `slip_cnt` within a few cycles of the second request. A wrong sync flag shows up as `sync_status` staying high through an offset change. A level/edge mix-up shows up when the input moves to another rotation while the request is held high: the offset then follows when it should stay, or stays when it should follow.

// File: rtl/rxwa_pkg.sv
package rxwa_pkg;
  typedef enum logic [1:0] {
    RXWA_BITSLIP = 2'd0,
    RXWA_MANUAL  = 2'd1,
    RXWA_DETLAT  = 2'd2,
    RXWA_HOLD    = 2'd3
  } rxwa_mode_e;
endpackage

// File: rtl/rxwa_slip_ctrl.sv
// Rising-edge detector for the slip request, with a holdoff window after every applied step.
module rxwa_slip_ctrl #(
  parameter int HOLD = 2,
  localparam int HW  = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bitslip,
  output logic step
);
  logic          bs_q;
  logic [HW-1:0] hold_cnt;

  assign step = enable && bitslip && !bs_q && (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bs_q     <= 1'b0;
      hold_cnt <= '0;
    end else begin
      bs_q <= bitslip;
      if (step)
        hold_cnt <= HW'(HOLD);
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - HW'(1);
    end
  end
endmodule

// File: rtl/rxwa_align_sync.sv
// Resynchronizes the align request and turns it into a realignment enable, acting on either its level or its edge.
module rxwa_align_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pattern_align,
  input  logic enable,
  input  logic level_mode,
  input  logic found,
  output logic fire
);
  logic [STAGES-1:0] sync_q;
  logic              req_s;
  logic              req_d;
  logic              rise;
  logic              armed;

  assign req_s = sync_q[STAGES-1];
  assign rise  = req_s && !req_d;
  assign fire  = enable && found && (level_mode ? req_s : (armed || rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      req_d  <= 1'b0;
      armed  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pattern_align};
      req_d  <= req_s;
      if (!enable || level_mode || fire)
        armed <= 1'b0;
      else if (rise)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rxwa_pattern_search.sv
// Compares every candidate offset against the pattern and encodes the lowest match.
module rxwa_pattern_search #(
  parameter int W   = 10,
  localparam int CW = $clog2(W)
) (
  input  logic [2*W-1:0] win,
  input  logic [W-1:0]   pattern,
  output logic           found,
  output logic [CW-1:0]  idx
);
  logic [W-1:0] match;

  for (genvar s = 0; s < W; s++) begin : g_cmp
    assign match[s] = (win[s +: W] == pattern);
  end

  assign found = |match;

  always_comb begin
    idx = '0;
    for (int s = W - 1; s >= 0; s--) begin
      if (match[s]) idx = CW'(s);
    end
  end
endmodule

// File: rtl/rxwa_barrel.sv
// Two-word history and the offset window, with the registered output word and its match flag.
module rxwa_barrel #(
  parameter int W   = 10,
  localparam int CW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   data_in,
  input  logic [CW-1:0]  ofs,
  input  logic [W-1:0]   pattern,
  output logic [2*W-1:0] win,
  output logic [W-1:0]   aligned,
  output logic [W-1:0]   data_out,
  output logic           pattern_detect
);
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  assign win     = {cur_q, prev_q};
  assign aligned = win[ofs +: W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q          <= '0;
      prev_q         <= '0;
      data_out       <= '0;
      pattern_detect <= 1'b0;
    end else begin
      cur_q          <= data_in;
      prev_q         <= cur_q;
      data_out       <= aligned;
      pattern_detect <= (aligned == pattern);
    end
  end
endmodule

// File: rtl/rx_word_aligner.sv
// Top level: offset register, mode decoding and the sync flag.
module rx_word_aligner #(
  parameter int W   = 10,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic [W-1:0]  data_in,
  input  logic          bitslip,
  input  logic          pattern_align,
  input  logic [W-1:0]  align_pattern,
  output logic [W-1:0]  data_out,
  output logic          pattern_detect,
  output logic          sync_status,
  output logic [CW-1:0] slip_cnt
);
  import rxwa_pkg::*;

  localparam bit LEVEL_WIDTH = (W == 10);

  rxwa_mode_e    mode;
  logic [CW-1:0] ofs;
  logic [CW-1:0] ofs_nxt;
  logic [2*W-1:0] win;
  logic [W-1:0]  aligned;
  logic          slip_step;
  logic          align_fire;
  logic          found;
  logic [CW-1:0] found_idx;
  logic          align_en;
  logic          level_mode;

  assign mode       = rxwa_mode_e'(mode_sel);
  assign align_en   = (mode == RXWA_MANUAL) || (mode == RXWA_DETLAT);
  assign level_mode = (mode == RXWA_MANUAL) && LEVEL_WIDTH;

  rxwa_slip_ctrl #(.HOLD(2)) u_slip (
    .clk     (clk),
    .rst     (rst),
    .enable  (mode == RXWA_BITSLIP),
    .bitslip (bitslip),
    .step    (slip_step)
  );

  rxwa_align_sync #(.STAGES(2)) u_align (
    .clk           (clk),
    .rst           (rst),
    .pattern_align (pattern_align),
    .enable        (align_en),
    .level_mode    (level_mode),
    .found         (found),
    .fire          (align_fire)
  );

  rxwa_barrel #(.W(W)) u_barrel (
    .clk            (clk),
    .rst            (rst),
    .data_in        (data_in),
    .ofs            (ofs),
    .pattern        (align_pattern),
    .win            (win),
    .aligned        (aligned),
    .data_out       (data_out),
    .pattern_detect (pattern_detect)
  );

  rxwa_pattern_search #(.W(W)) u_search (
    .win     (win),
    .pattern (align_pattern),
    .found   (found),
    .idx     (found_idx)
  );

  always_comb begin
    ofs_nxt = ofs;
    if (slip_step)
      ofs_nxt = (ofs == CW'(W - 1)) ? '0 : ofs + CW'(1);
    else if (align_fire)
      ofs_nxt = found_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs         <= '0;
      sync_status <= 1'b0;
    end else begin
      ofs <= ofs_nxt;
      if (ofs_nxt != ofs)
        sync_status <= 1'b0;
      else if (aligned == align_pattern)
        sync_status <= 1'b1;
    end
  end

  assign slip_cnt = ofs;
endmodule

// File: rtl/rxwa_checker.sv
module rxwa_checker #(
  parameter int W   = 10,
  localparam int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode_sel,
  input logic [W-1:0]  align_pattern,
  input logic [W-1:0]  data_out,
  input logic          pattern_detect,
  input logic          sync_status,
  input logic [CW-1:0] slip_cnt,
  input logic          fire
);
  AST_SLIP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    slip_cnt <= CW'(W - 1)); // R3

  AST_BITSLIP_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd0) |=> (slip_cnt == $past(slip_cnt)) ||
      (($past(slip_cnt) == CW'(W - 1)) ? (slip_cnt == '0)
                                       : (slip_cnt == $past(slip_cnt) + CW'(1)))); // R2

  AST_SLIP_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'd0) && ($past(mode_sel) == 2'd0) && (slip_cnt != $past(slip_cnt)))
      |=> $stable(slip_cnt)); // R4

  AST_BITSLIP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (($past(mode_sel) != 2'd0) && !$past(fire)) |-> $stable(slip_cnt)); // R5

  AST_SYNC_DROP: assert property (@(posedge clk) disable iff (rst)
    (slip_cnt != $past(slip_cnt)) |-> !sync_status); // R11

  AST_PDET_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(align_pattern)) |-> (pattern_detect == (data_out == align_pattern))); // R10
endmodule

bind rx_word_aligner rxwa_checker #(.W(W)) u_rxwa_checker (
  .clk            (clk),
  .rst            (rst),
  .mode_sel       (mode_sel),
  .align_pattern  (align_pattern),
  .data_out       (data_out),
  .pattern_detect (pattern_detect),
  .sync_status    (sync_status),
  .slip_cnt       (slip_cnt),
  .fire           (align_fire)
);

// File: tb/test_rx_word_aligner.sv
module test_rx_word_aligner;
  localparam logic [9:0]  P10 = 10'h17C;
  localparam logic [15:0] P16 = 16'h016F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]  a_mode = 2'd0;
  logic [9:0]  a_din  = '0;
  logic        a_bs   = 1'b0;
  logic        a_pa   = 1'b0;
  logic [9:0]  a_pat  = P10;
  logic [9:0]  a_dout;
  logic        a_pd, a_sync;
  logic [3:0]  a_slip;

  logic [1:0]  b_mode = 2'd0;
  logic [15:0] b_din  = '0;
  logic        b_bs   = 1'b0;
  logic        b_pa   = 1'b0;
  logic [15:0] b_pat  = P16;
  logic [15:0] b_dout;
  logic        b_pd, b_sync;
  logic [3:0]  b_slip;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rx_word_aligner #(.W(10)) i_rx_word_aligner (
    .clk(clk), .rst(rst), .mode_sel(a_mode), .data_in(a_din), .bitslip(a_bs),
    .pattern_align(a_pa), .align_pattern(a_pat), .data_out(a_dout),
    .pattern_detect(a_pd), .sync_status(a_sync), .slip_cnt(a_slip));

  rx_word_aligner #(.W(16)) i_rx_word_aligner_w16 (
    .clk(clk), .rst(rst), .mode_sel(b_mode), .data_in(b_din), .bitslip(b_bs),
    .pattern_align(b_pa), .align_pattern(b_pat), .data_out(b_dout),
    .pattern_detect(b_pd), .sync_status(b_sync), .slip_cnt(b_slip));

  function automatic logic [9:0] rotr10(logic [9:0] x, int s);
    for (int i = 0; i < 10; i++) rotr10[i] = x[(i + s) % 10];
  endfunction
  function automatic logic [9:0] rotl10(logic [9:0] x, int k);
    for (int i = 0; i < 10; i++) rotl10[i] = x[(i - k + 10) % 10];
  endfunction
  function automatic logic [15:0] rotl16(logic [15:0] x, int k);
    for (int i = 0; i < 16; i++) rotl16[i] = x[(i - k + 16) % 16];
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_slip();
    a_bs = 1'b1; cyc(1); a_bs = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(3);
    check("R1 slip_cnt in reset", 32'(a_slip), 0);
    check("R1 sync in reset", 32'(a_sync), 0);
    check("R1 pdet in reset", 32'(a_pd), 0);
    check("R1 data_out in reset", 32'(a_dout), 0);
    rst = 1'b0;
    check("R1 slip_cnt after reset", 32'(a_slip), 0);
  endtask

  task automatic t_bitslip();
    a_mode = 2'd0; a_din = P10; cyc(6);
    check("R2 zero offset word", 32'(a_dout), 32'(P10));
    check("R10 pdet on pattern", 32'(a_pd), 1);
    check("R11 sync on pattern", 32'(a_sync), 1);
    for (int s = 1; s <= 3; s++) begin
      pulse_slip();
      check("R2 slip count", 32'(a_slip), 32'(s));
      check("R2 slipped word", 32'(a_dout), 32'(rotr10(P10, s)));
      if (s == 1) begin
        check("R11 sync cleared by slip", 32'(a_sync), 0);
        check("R10 pdet off when rotated", 32'(a_pd), 0);
      end
    end
    a_bs = 1'b1; cyc(1); a_bs = 1'b0; cyc(1); a_bs = 1'b1; cyc(1); a_bs = 1'b0; cyc(4);
    check("R4 edge in holdoff ignored", 32'(a_slip), 4);
    for (int s = 5; s <= 9; s++) pulse_slip();
    check("R3 top offset", 32'(a_slip), 9);
    check("R3 top offset word", 32'(a_dout), 32'(rotr10(P10, 9)));
    pulse_slip();
    check("R3 wrap to zero", 32'(a_slip), 0);
    check("R3 wrapped word", 32'(a_dout), 32'(P10));
    check("R11 sync back on pattern", 32'(a_sync), 1);
  endtask

  task automatic t_ignore();
    logic [9:0] exp_word;
    exp_word = rotl10(P10, 2);
    a_pa = 1'b0; a_din = exp_word;
    for (int m = 1; m <= 3; m++) begin
      a_mode = 2'(m); cyc(4);
      pulse_slip();
      check("R5 slip ignored count", 32'(a_slip), 0);
      check("R5 slip ignored word", 32'(a_dout), 32'(exp_word));
    end
    a_mode = 2'd3; a_pa = 1'b1; cyc(8);
    check("R5 hold mode ignores align", 32'(a_slip), 0);
    a_pa = 1'b0; cyc(4);
  endtask

  task automatic t_level();
    a_mode = 2'd1; a_din = rotl10(P10, 3); cyc(3);
    a_pa = 1'b1; cyc(8);
    check("R9 slip after align", 32'(a_slip), 3);
    check("R9 aligned word", 32'(a_dout), 32'(P10));
    check("R10 pdet after align", 32'(a_pd), 1);
    check("R11 sync after align", 32'(a_sync), 1);
    a_din = rotl10(P10, 7); cyc(8);
    check("R6 level follows pattern", 32'(a_slip), 7);
    check("R6 level word", 32'(a_dout), 32'(P10));
    a_pa = 1'b0; cyc(4);
    a_din = rotl10(P10, 2); cyc(6);
    check("R6 released holds offset", 32'(a_slip), 7);
    check("R6 released word", 32'(a_dout), 32'(rotr10(rotl10(P10, 2), 7)));
    check("R10 pdet off on mismatch", 32'(a_pd), 0);
    check("R11 sync held while offset held", 32'(a_sync), 1);
  endtask

  task automatic t_detlat();
    a_mode = 2'd2; a_din = rotl10(P10, 4); cyc(3);
    a_pa = 1'b1; cyc(8);
    check("R8 edge align", 32'(a_slip), 4);
    a_din = rotl10(P10, 6); cyc(8);
    check("R8 no follow while high", 32'(a_slip), 4);
    check("R10 pdet off", 32'(a_pd), 0);
    a_pa = 1'b0; cyc(4); a_pa = 1'b1; cyc(8);
    check("R8 second edge realigns", 32'(a_slip), 6);
    check("R9 realigned word", 32'(a_dout), 32'(P10));
    a_pa = 1'b0; cyc(4);
  endtask

  task automatic t_edge16();
    b_mode = 2'd1; b_din = rotl16(P16, 5); cyc(3);
    b_pa = 1'b1; cyc(8);
    check("R7 edge align w16", 32'(b_slip), 5);
    check("R9 aligned word w16", 32'(b_dout), 32'(P16));
    b_din = rotl16(P16, 9); cyc(8);
    check("R7 single realign w16", 32'(b_slip), 5);
    b_pa = 1'b0; cyc(4); b_pa = 1'b1; cyc(8);
    check("R7 new edge w16", 32'(b_slip), 9);
    check("R10 pdet w16", 32'(b_pd), 1);
    b_pa = 1'b0; cyc(4);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(1);
    t_reset();
    t_bitslip();
    t_ignore();
    t_level();
    t_detlat();
    t_edge16();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule